// File: doc/BRIEF.md
# AES Key-Generation Assist Unit

This unit builds the helper pattern that an AES key-expansion step combines with the previous round key. It accepts a 128-bit source operand and an 8-bit round constant. From the source it takes only the two odd-numbered 32-bit words, words 1 and 3. Each of these is passed byte by byte through the forward AES substitution box. The substituted word appears once as it is, and once rotated right by one byte with the round constant XORed into its lowest byte.

The surrounding key-schedule sequencer raises the valid strobe for one cycle with the operand and the constant. One clock later the 128-bit result is registered and the done strobe pulses for one cycle. The result holds its value until the next valid strobe. A synchronous reset clears both the result and the done strobe.

Top module: `kgaAssist`

## Requirements
- R1: While rst is high at a rising clock edge, resData becomes all zeros and resDone becomes 0 at that edge.
- R2: resDone is 1 in exactly the cycle after a cycle in which srcValid was 1, and is 0 otherwise.
- R3: After a valid strobe, output word 0 (resData[31:0]) is input word 1 (srcData[63:32]) with each of its four bytes replaced by its S-box value.
- R4: After a valid strobe, output word 1 (resData[63:32]) is the substituted input word 1, rotated right by 8 bits so that its bits 7:0 move to bits 31:24, then XORed with the round constant zero-extended to 32 bits.
- R5: After a valid strobe, output word 2 (resData[95:64]) is input word 3 (srcData[127:96]) substituted byte by byte.
- R6: After a valid strobe, output word 3 (resData[127:96]) is the substituted input word 3, rotated right by 8 bits, then XORed with the zero-extended round constant.
- R7: The round constant changes only bits 7:0 of output words 1 and 3. Output words 0 and 2 and the upper 24 bits of words 1 and 3 do not depend on it.
- R8: Input words 0 (srcData[31:0]) and 2 (srcData[95:64]) have no effect on resData.
- R9: While srcValid is 0, resData holds its previous value.
- R10: The S-box is the standard AES forward substitution: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, where 0 maps to 0, followed by the affine transform with constant 0x63. For example, 0x00 maps to 0x63 and 0x01 maps to 0x7C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcValid | input | 1 | One-cycle strobe that presents an operand |
| srcData | input | 128 | Source operand; only words 1 and 3 are used |
| roundConst | input | 8 | Round constant, zero-extended before the XOR |
| resData | output | 128 | Registered assist result |
| resDone | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that srcValid and roundConst are settled before each rising edge. They also assume that no valid strobe coincides with reset, because a reset edge would then clear a result that the properties expect to hold. The bench drives all inputs on falling edges. It lowers srcValid before it raises or lowers reset. This keeps every sampled edge inside those assumptions, including the back-to-back strobes and the reset in the middle of the run.

// File: rtl/kga_pkg.sv
package kga_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int DATA_W = 128;

  typedef struct packed {
    logic capture;
    logic clear;
  } kgaStrobes_t;
endpackage

// File: rtl/kgaCtrl.sv
module kgaCtrl
  import kga_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        srcValid,
  output kgaStrobes_t strobes,
  output logic        resDone
);
  always_comb begin
    strobes.clear   = rst;
    strobes.capture = srcValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) resDone <= 1'b0;
    else     resDone <= srcValid;
  end
endmodule

// File: rtl/kgaDatapath.sv
module kgaDatapath
  import kga_pkg::*;
#(
  parameter int BYTE_BITS = BYTE_W,
  parameter int WORD_BITS = WORD_W,
  parameter int NUM_SEL   = 2
) (
  input  logic                          clk,
  input  kgaStrobes_t                   strobes,
  input  logic [NUM_SEL*WORD_BITS-1:0]  selWords,
  input  logic [BYTE_BITS-1:0]          roundConst,
  output logic [2*NUM_SEL*WORD_BITS-1:0] resData
);
  localparam int BYTES_PER_WORD = WORD_BITS / BYTE_BITS;
  localparam int OUT_W          = 2 * NUM_SEL * WORD_BITS;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // a^254 equals the inverse of a (and 0 for a = 0)
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] sq;
    logic [7:0] e;
    r  = 8'h01;
    sq = a;
    e  = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gfMul(r, sq);
      sq = gfMul(sq, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] fwdSub(input logic [7:0] a);
    logic [7:0] v;
    v = gfInv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  logic [OUT_W-1:0] nextData;

  for (genvar g = 0; g < NUM_SEL; g++) begin : gSel
    logic [WORD_BITS-1:0] srcWord;
    logic [WORD_BITS-1:0] subWord;
    logic [WORD_BITS-1:0] rotWord;
    assign srcWord = selWords[g*WORD_BITS +: WORD_BITS];
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : gByte
      assign subWord[b*BYTE_BITS +: BYTE_BITS] = fwdSub(srcWord[b*BYTE_BITS +: BYTE_BITS]);
    end
    assign rotWord = {subWord[BYTE_BITS-1:0], subWord[WORD_BITS-1:BYTE_BITS]};
    assign nextData[(2*g)*WORD_BITS +: WORD_BITS]   = subWord;
    assign nextData[(2*g+1)*WORD_BITS +: WORD_BITS] =
      rotWord ^ {{(WORD_BITS-BYTE_BITS){1'b0}}, roundConst};
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)        resData <= '0;
    else if (strobes.capture) resData <= nextData;
  end
endmodule

// File: rtl/kgaAssist.sv
module kgaAssist
  import kga_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          srcValid,
  input  logic [127:0]  srcData,
  input  logic [7:0]    roundConst,
  output logic [127:0]  resData,
  output logic          resDone
);
  localparam int NUM_SEL = DATA_W / (2 * WORD_W);

  kgaStrobes_t                 strobes;
  logic [NUM_SEL*WORD_W-1:0]   selWords;
  logic                        unusedEvenWords;

  assign selWords        = {srcData[127:96], srcData[63:32]};
  assign unusedEvenWords = ^{srcData[95:64], srcData[31:0]};

  kgaCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .srcValid (srcValid),
    .strobes  (strobes),
    .resDone  (resDone)
  );

  kgaDatapath #(
    .BYTE_BITS (BYTE_W),
    .WORD_BITS (WORD_W),
    .NUM_SEL   (NUM_SEL)
  ) uData (
    .clk        (clk),
    .strobes    (strobes),
    .selWords   (selWords),
    .roundConst (roundConst),
    .resData    (resData)
  );
endmodule

// File: rtl/kgaAssistChk.sv
module kgaAssistChk (
  input logic         clk,
  input logic         rst,
  input logic         srcValid,
  input logic [7:0]   roundConst,
  input logic [127:0] resData,
  input logic         resDone
);
  // R2: done follows valid by one cycle
  a_r2_done_after_valid: assert property (@(posedge clk) disable iff (rst)
    srcValid |=> resDone);
  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !srcValid |=> !resDone);
  // R9: result holds without a strobe
  a_r9_hold_result: assert property (@(posedge clk) disable iff (rst)
    !srcValid |=> $stable(resData));
  // R4: word 1 is word 0 rotated right one byte with the constant in its low byte
  a_r4_word1_rot: assert property (@(posedge clk) disable iff (rst)
    srcValid |=> resData[63:32] ==
      ({resData[7:0], resData[31:8]} ^ {24'd0, $past(roundConst)}));
  // R6: same relation between words 3 and 2
  a_r6_word3_rot: assert property (@(posedge clk) disable iff (rst)
    srcValid |=> resData[127:96] ==
      ({resData[71:64], resData[95:72]} ^ {24'd0, $past(roundConst)}));
endmodule

bind kgaAssist kgaAssistChk chk (.*);

// File: tb/tb_kgaAssist.sv
module tb_kgaAssist;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         srcValid = 1'b0;
  logic [127:0] srcData = '0;
  logic [7:0]   roundConst = '0;
  logic [127:0] resData;
  logic         resDone;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sboxRef [256];

  always #10 clk = ~clk;

  kgaAssist dut (
    .clk(clk), .rst(rst), .srcValid(srcValid), .srcData(srcData),
    .roundConst(roundConst), .resData(resData), .resDone(resDone)
  );

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    logic [7:0] inv;
    logic [7:0] o;
    inv = 8'h00;
    for (int c = 1; c < 256; c++) if (refMul(a, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
             ^ ((8'h63 >> i) & 8'h01) != 0;
    return o;
  endfunction

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {sboxRef[w[31:24]], sboxRef[w[23:16]], sboxRef[w[15:8]], sboxRef[w[7:0]]};
  endfunction

  function automatic logic [127:0] expect128(input logic [127:0] s, input logic [7:0] rc);
    logic [31:0] a;
    logic [31:0] b;
    a = subW(s[63:32]);
    b = subW(s[127:96]);
    return {({b[7:0], b[31:8]} ^ {24'd0, rc}), b, ({a[7:0], a[31:8]} ^ {24'd0, rc}), a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] s, input logic [7:0] rc);
    logic [127:0] e;
    e = expect128(s, rc);
    @(negedge clk);
    srcData = s; roundConst = rc; srcValid = 1'b1;
    @(negedge clk);
    srcValid = 1'b0;
    check(resDone == 1'b1, "R2", 128'(resDone), 128'd1);
    check(resData[31:0] == e[31:0], "R3", 128'(resData[31:0]), 128'(e[31:0]));
    check(resData[63:32] == e[63:32], "R4", 128'(resData[63:32]), 128'(e[63:32]));
    check(resData[95:64] == e[95:64], "R5", 128'(resData[95:64]), 128'(e[95:64]));
    check(resData[127:96] == e[127:96], "R6", 128'(resData[127:96]), 128'(e[127:96]));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [127:0] held;
    logic [127:0] first;
    for (int v = 0; v < 256; v++) sboxRef[v] = refSbox(8'(v));
    check(sboxRef[0] == 8'h63 && sboxRef[1] == 8'h7C, "R10",
          128'({sboxRef[0], sboxRef[1]}), 128'h637C);

    repeat (2) @(negedge clk);
    check(resData == '0 && resDone == 1'b0, "R1", resData, '0);
    rst = 1'b0;

    // R3 R4 R5 R6 R10: every byte value in every byte lane
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b0;
      b0 = 8'(v);
      runOp({b0 ^ 8'h5A, b0 + 8'd3, ~b0, b0 + 8'd77,
             32'hDEADBEEF ^ {4{b0}},
             b0 + 8'd9, b0, b0 ^ 8'hC3, b0 + 8'd128,
             32'h0BADF00D + 32'(v)}, b0 ^ 8'hA5);
    end

    // R2 R9: result holds and done drops without a strobe
    held = resData;
    @(negedge clk);
    check(resDone == 1'b0, "R2", 128'(resDone), 128'd0);
    srcData = ~srcData; roundConst = ~roundConst;
    repeat (3) @(negedge clk);
    check(resData == held, "R9", resData, held);

    // R7: round constant touches only low bytes of words 1 and 3
    runOp(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 8'h00);
    first = resData;
    runOp(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 8'hFF);
    check((first ^ resData) == {24'd0, 8'hFF, 32'd0, 24'd0, 8'hFF, 32'd0}, "R7",
          first ^ resData, {24'd0, 8'hFF, 32'd0, 24'd0, 8'hFF, 32'd0});

    // R8: even input words are ignored
    runOp(128'h1111_2222_0000_0000_3333_4444_0000_0000, 8'h1B);
    first = resData;
    runOp(128'h1111_2222_FFFF_FFFF_3333_4444_A5A5_5A5A, 8'h1B);
    check(resData == first, "R8", resData, first);

    // R2: back-to-back strobes
    @(negedge clk);
    srcData = 128'h0; roundConst = 8'h01; srcValid = 1'b1;
    @(negedge clk);
    srcData = 128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000;
    @(negedge clk);
    srcValid = 1'b0;
    check(resDone == 1'b1 && resData == expect128(srcData, 8'h01), "R2",
          resData, expect128(srcData, 8'h01));

    // R1: mid-run reset clears result and done
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(resData == '0 && resDone == 1'b0, "R1", resData, '0);
    rst = 1'b0;
    runOp(128'h0000_0001_0000_0000_0000_0000_0000_0000, 8'h36);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule